// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Flagging

This block computes a 32-bit integer quotient, signed or unsigned, with a restoring shift-subtract loop that settles one quotient bit per clock. A caller presents dividend, divisor and a 4-bit ALU sub-code together with a one-cycle start strobe. When the divide finishes, the block raises a one-cycle done pulse. In the same cycle it presents the quotient with a result write-enable and the value and write-enable for the one status flag that the operation owns.

A zero divisor is caught the moment the operation is accepted and takes a short path. Which flag reports it depends on signedness: a signed divide sets the overflow flag and an unsigned divide sets the carry flag. The destination is not written, and a range-exception pulse follows if the caller's exception enable was high. A signed divide never drives the carry flag, and an unsigned divide never drives the overflow flag.

Top module: `idiv_unit`

## Requirements
- R1: A start is accepted only with sub-code 4'h9 (signed divide) or 4'hA (unsigned divide). A start with any other sub-code produces no done pulse and no write-enable.
- R2: A signed divide with a nonzero divisor writes the quotient truncated toward zero (res_we=1) and clears overflow (ov_we=1, ov_val=0). It does not drive carry (cy_we=0).
- R3: An unsigned divide with a nonzero divisor writes the unsigned quotient (res_we=1) and clears carry (cy_we=1, cy_val=0). It does not drive overflow (ov_we=0).
- R4: A signed divide by zero sets overflow (ov_we=1, ov_val=1), leaves res_we low, and does not drive carry.
- R5: An unsigned divide by zero sets carry (cy_we=1, cy_val=1), leaves res_we low, and does not drive overflow.
- R6: range_exc pulses with done only for a zero divisor with exc_en high at start. It stays low for every nonzero divisor, whatever exc_en is.
- R7: Signed 32'h80000000 divided by 32'hFFFFFFFF returns 32'h80000000 with overflow cleared.
- R8: Take the edge that samples start as edge 0. Done is high after edge 0 for a zero divisor and after edge 32 for a nonzero divisor.
- R9: A start raised while a divide is in progress is ignored. The running divide's result is unchanged, and no extra done follows.
- R10: done, res_we, ov_we, cy_we and range_exc are single-cycle pulses and are low outside a completion cycle. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a divide (sampled when idle) |
| op_sel | input | 4 | ALU sub-code: 4'h9 signed, 4'hA unsigned |
| exc_en | input | 1 | Range-exception enable |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| quotient | output | 32 | Quotient, valid while res_we is high |
| res_we | output | 1 | Destination write-enable pulse |
| ov_val | output | 1 | Overflow flag value |
| ov_we | output | 1 | Overflow flag write-enable pulse |
| cy_val | output | 1 | Carry flag value |
| cy_we | output | 1 | Carry flag write-enable pulse |
| range_exc | output | 1 | Range-exception pulse |
| done | output | 1 | Completion pulse |

## Verification
On every cycle, the embedded assertions check the following. Completion outputs never last two cycles. A write-enable never appears without done. The two flag enables are never both high. An exception never coincides with a result write. An accepted zero divisor finishes on the next cycle, while a nonzero one does not. The partial remainder stays below the divisor magnitude. Only the directed scenarios can show that quotient values are numerically right for each sign combination, that the most-negative-by-minus-one case returns its dividend, that the 33-cycle latency holds, and that starts during a run or with a foreign sub-code leave no trace.

// File: rtl/idiv_pkg.sv
// Package: shared constants and types for the iterative divider.
// Assumes a 4-bit ALU sub-code selects the divide flavour.
package idiv_pkg;
    localparam logic [3:0] SUB_SDIV = 4'h9;
    localparam logic [3:0] SUB_UDIV = 4'hA;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/idiv_ctrl.sv
// Sequencer: accepts an operation when idle, sends zero divisors to the
// short path, and counts WIDTH restoring steps for all others.
// Assumes op_sel, divisor_zero and start are stable in the start cycle.
module idiv_ctrl
    import idiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] op_sel,
    input  logic       divisor_zero,
    output logic       accept,
    output logic       load,
    output logic       step,
    output logic       fin_zero,
    output logic       fin_calc,
    output logic       fin_signed
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             sgn_r;
    logic             op_ok;

    // Decode a supported sub-code and qualify the strobe.
    always_comb begin
        op_ok    = (op_sel == SUB_SDIV) || (op_sel == SUB_UDIV);
        accept   = start && (phase == PH_IDLE) && op_ok;
        load     = accept && !divisor_zero;
        fin_zero = accept && divisor_zero;
        step     = (phase == PH_RUN);
        fin_calc = step && (cnt == LAST);
        fin_signed = fin_zero ? (op_sel == SUB_SDIV) : sgn_r;
    end

    // Phase, step counter and captured signedness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sgn_r <= 1'b0;
        end else if (load) begin
            phase <= PH_RUN;
            cnt   <= '0;
            sgn_r <= (op_sel == SUB_SDIV);
        end else if (fin_calc) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: a running divide is not cut short by a new start
    a_r9_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fin_calc && start) |=> step);
endmodule

// File: rtl/idiv_core.sv
// Datapath: converts operands to magnitudes on load, then performs one
// restoring shift-subtract per step. Presents the sign-corrected
// quotient of the step in flight.
// Assumes load is only raised with a nonzero divisor.
module idiv_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quot_final
);
    logic [WIDTH-1:0] rem_r, quo_r, dvs_r;
    logic             neg_r;
    logic             a_neg, b_neg;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic [WIDTH:0]   rem_sh, diff;
    logic             fits;
    logic [WIDTH-1:0] rem_nx, quo_nx;

    // Operand magnitudes and quotient sign for signed mode.
    always_comb begin
        a_neg = is_signed && dividend[WIDTH-1];
        b_neg = is_signed && divisor[WIDTH-1];
        a_mag = a_neg ? (~dividend + 1'b1) : dividend;
        b_mag = b_neg ? (~divisor + 1'b1) : divisor;
    end

    // One restoring step: shift in next dividend bit, trial subtract.
    always_comb begin
        rem_sh = {rem_r, quo_r[WIDTH-1]};
        diff   = rem_sh - {1'b0, dvs_r};
        fits   = !diff[WIDTH];
        rem_nx = fits ? diff[WIDTH-1:0] : rem_sh[WIDTH-1:0];
        quo_nx = {quo_r[WIDTH-2:0], fits};
        quot_final = neg_r ? (~quo_nx + 1'b1) : quo_nx;
    end

    // Working registers: load magnitudes, then iterate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            dvs_r <= '0;
            neg_r <= 1'b0;
        end else if (load) begin
            rem_r <= '0;
            quo_r <= a_mag;
            dvs_r <= b_mag;
            neg_r <= a_neg ^ b_neg;
        end else if (step) begin
            rem_r <= rem_nx;
            quo_r <= quo_nx;
        end
    end

    // R2/R3: the partial remainder never reaches the divisor magnitude
    a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_r < dvs_r));
endmodule

// File: rtl/idiv_result.sv
// Output stage: registers quotient, write-enables, flag values and the
// exception pulse for exactly one cycle per completion.
// Assumes fin_zero and fin_calc are never high together.
module idiv_result #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_zero,
    input  logic             fin_calc,
    input  logic             fin_signed,
    input  logic             exc_en,
    input  logic [WIDTH-1:0] quot_final,
    output logic [WIDTH-1:0] quotient,
    output logic             res_we,
    output logic             ov_val,
    output logic             ov_we,
    output logic             cy_val,
    output logic             cy_we,
    output logic             range_exc,
    output logic             done
);
    // Completion register: pulses clear themselves the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            res_we    <= 1'b0;
            ov_val    <= 1'b0;
            ov_we     <= 1'b0;
            cy_val    <= 1'b0;
            cy_we     <= 1'b0;
            range_exc <= 1'b0;
            done      <= 1'b0;
        end else begin
            done      <= fin_zero || fin_calc;
            res_we    <= fin_calc;
            ov_we     <= (fin_zero || fin_calc) && fin_signed;
            cy_we     <= (fin_zero || fin_calc) && !fin_signed;
            ov_val    <= fin_zero && fin_signed;
            cy_val    <= fin_zero && !fin_signed;
            range_exc <= fin_zero && exc_en;
            if (fin_calc) quotient <= quot_final;
        end
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: write-enables only accompany done
    a_r10_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || ov_we || cy_we || range_exc) |-> done);
    // R2/R3: one flag per operation
    a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(ov_we && cy_we));
    // R4/R5: an exception never comes with a result write
    a_r5_exc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> !res_we);
endmodule

// File: rtl/idiv_unit.sv
// Top: iterative signed/unsigned divider with zero-divisor short path.
// Assumes the caller holds operands stable only in the start cycle.
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       op_sel,
    input  logic             exc_en,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic             res_we,
    output logic             ov_val,
    output logic             ov_we,
    output logic             cy_val,
    output logic             cy_we,
    output logic             range_exc,
    output logic             done
);
    logic             divisor_zero;
    logic             accept, load, step, fin_zero, fin_calc, fin_signed;
    logic [WIDTH-1:0] quot_final;

    // Zero-divisor detection ahead of the loop.
    always_comb divisor_zero = (divisor == '0);

    idiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .divisor_zero(divisor_zero), .accept(accept), .load(load),
        .step(step), .fin_zero(fin_zero), .fin_calc(fin_calc),
        .fin_signed(fin_signed)
    );

    idiv_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .is_signed(op_sel == SUB_SDIV), .dividend(dividend),
        .divisor(divisor), .quot_final(quot_final)
    );

    idiv_result #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .fin_zero(fin_zero), .fin_calc(fin_calc),
        .fin_signed(fin_signed), .exc_en(exc_en), .quot_final(quot_final),
        .quotient(quotient), .res_we(res_we), .ov_val(ov_val), .ov_we(ov_we),
        .cy_val(cy_val), .cy_we(cy_we), .range_exc(range_exc), .done(done)
    );

    // R8: an accepted zero divisor completes on the next cycle
    a_r8_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && divisor_zero) |=> (done && !res_we));
    // R8: a nonzero divisor does not complete on the next cycle
    a_r8_nonzero_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !divisor_zero) |=> !done);
endmodule

// File: tb/idiv_unit_test.sv
`timescale 1ns/100ps
module idiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_sel = 4'h0;
    logic        exc_en = 1'b0;
    logic [31:0] dividend = '0, divisor = '0;
    logic [31:0] quotient;
    logic        res_we, ov_val, ov_we, cy_val, cy_we, range_exc, done;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    idiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .exc_en(exc_en), .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .res_we(res_we), .ov_val(ov_val), .ov_we(ov_we),
        .cy_val(cy_val), .cy_we(cy_we), .range_exc(range_exc), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Launch one divide, measure latency and check every completion output.
    task automatic run_op(input string rq, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b, input logic exc);
        logic sgn, zero, got;
        logic [31:0] expq;
        int lat;
        sgn  = (op == 4'h9);
        zero = (b == 0);
        if (zero) expq = 32'h0;
        else if (sgn && a == 32'h80000000 && b == 32'hFFFFFFFF) expq = 32'h80000000;
        else if (sgn) expq = $signed(a) / $signed(b);
        else expq = a / b;
        @(negedge clk);
        op_sel = op; dividend = a; divisor = b; exc_en = exc; start = 1'b1;
        lat = 0; got = 1'b0;
        while (!got && lat < 40) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) got = 1'b1;
        end
        chk({rq, " R8 latency"}, lat, zero ? 1 : 33);
        chk({rq, " res_we"}, res_we, !zero);
        if (!zero) chk({rq, " quotient"}, quotient, expq);
        chk({rq, " ov_we"}, ov_we, sgn);
        chk({rq, " ov_val"}, ov_val, sgn && zero);
        chk({rq, " cy_we"}, cy_we, !sgn);
        chk({rq, " cy_val"}, cy_val, !sgn && zero);
        chk({rq, " R6 range_exc"}, range_exc, zero && exc);
        @(negedge clk);
        chk({rq, " R10 pulses low"}, {done, res_we, ov_we, cy_we, range_exc}, 0);
    endtask

    // R1: an unsupported sub-code leaves no completion.
    task automatic bad_code;
        int seen = 0;
        @(negedge clk);
        op_sel = 4'h3; dividend = 32'd100; divisor = 32'd7; start = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done || res_we) seen++;
        end
        chk("R1 foreign sub-code ignored", seen, 0);
    endtask

    // R9: a start during a run is ignored.
    task automatic busy_start;
        int lat = 0, extra = 0;
        logic got = 1'b0;
        @(negedge clk);
        op_sel = 4'hA; dividend = 32'd1000; divisor = 32'd10; exc_en = 1'b0; start = 1'b1;
        while (!got && lat < 40) begin
            @(negedge clk);
            lat++;
            start = (lat == 5);
            if (lat == 5) begin dividend = 32'd9; divisor = 32'd0; op_sel = 4'h9; end
            if (done) got = 1'b1;
        end
        start = 1'b0;
        chk("R9 latency unchanged", lat, 33);
        chk("R9 quotient of first op", quotient, 32'd100);
        chk("R9 no flag from second op", {ov_we, range_exc}, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9 no extra done", extra, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset outputs", {quotient[0], done, res_we, ov_val, ov_we,
                                  cy_val, cy_we, range_exc}, 0);
        chk("R10 reset quotient", quotient, 0);
        run_op("R2 pos/pos",   4'h9, 32'd100, 32'd7, 1'b1);
        run_op("R2 neg/pos",   4'h9, -32'sd100, 32'd7, 1'b0);
        run_op("R2 pos/neg",   4'h9, 32'd100, -32'sd7, 1'b0);
        run_op("R2 neg/neg",   4'h9, -32'sd7, -32'sd100, 1'b0);
        run_op("R7 min/-1",    4'h9, 32'h80000000, 32'hFFFFFFFF, 1'b1);
        run_op("R3 unsigned",  4'hA, 32'hFFFFFFFF, 32'd3, 1'b1);
        run_op("R3 big divisor", 4'hA, 32'h80000000, 32'hFFFFFFFF, 1'b0);
        run_op("R3 unsigned /1", 4'hA, 32'h12345678, 32'd1, 1'b0);
        run_op("R4 signed zero exc",   4'h9, 32'd55, 32'd0, 1'b1);
        run_op("R4 signed zero noexc", 4'h9, 32'd55, 32'd0, 1'b0);
        run_op("R5 unsigned zero exc", 4'hA, 32'd55, 32'd0, 1'b1);
        run_op("R5 unsigned zero noexc", 4'hA, 32'd0, 32'd0, 1'b0);
        bad_code();
        busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule